// File: doc/BRIEF.md
# PWM Feedback High/Low Pair Capture

This block sits behind a duration-measuring input that reports each completed period of a PWM feedback signal as a result: the duration in clock cycles, the level that was held during it, and a sequence count that advances by one for every completed period. The measuring input holds its most recent result until the next one lands. This block watches that held result and assembles a consistent pair: a high period together with the low period that came directly after it.

Every reported pair has high-then-low order and spans no missed period. A low followed by a high is never paired, and a sequence jump between the high and the low throws the pending high away. The block reads the held result rather than waiting for an edge. So a high period that is already sitting in the measuring buffer when the block starts is used at once, and a first pair arrives within one feedback cycle.

Each pair comes out with a one-clock strobe and its period sum (high plus low). Downstream logic can then form the duty ratio, which stays stable even when the feedback source's own clock drifts. The durations are kept at 16 bits by default, which is well beyond the 12-bit resolution the position math needs.

Top module: `pwm_pair_capture`

## Requirements
- R1: While rst_ni is low and after its release, pair_valid_o, high_dur_o, low_dur_o and period_o are 0, and the block is waiting for a high result with no result yet seen.
- R2: A pair is reported only when a low result (res_level_i = 0) directly follows an accepted high result (res_level_i = 1). A low followed by a high never forms a pair.
- R3: A result counts as new when res_valid_i is 1 and either no result has been seen since reset or res_seq_i differs from the sequence number of the last consumed result. A result held on the inputs is consumed exactly once.
- R4: While a high is pending, a new low result whose res_seq_i is not the pending high's sequence number plus one (modulo 2^SEQ_W) discards the pending high. No pair is reported, and the block returns to waiting for a high.
- R5: A high result already held on the inputs when reset is released is accepted on the first clock edge, so the following low completes a pair.
- R6: pair_valid_o is high for exactly one clock, in the cycle after the edge at which the closing low result is sampled.
- R7: high_dur_o, low_dur_o and period_o change only together with pair_valid_o and hold their values until the next pair.
- R8: period_o equals high_dur_o plus low_dur_o at DUR_W+1 bits, so even the largest durations do not overflow.
- R9: A new high result that arrives while a high is already pending replaces the pending high, and the block keeps waiting for a low.
- R10: A low result that arrives while the block is waiting for a high is consumed and has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_valid_i | input | 1 | Measuring buffer holds a result |
| res_level_i | input | 1 | Level held during the measured period, 1 = high, 0 = low |
| res_dur_i | input | DUR_W | Measured duration in clock cycles |
| res_seq_i | input | SEQ_W | Sequence count of the result, +1 per completed period |
| pair_valid_o | output | 1 | One-clock strobe for a new pair |
| high_dur_o | output | DUR_W | High duration of the last pair |
| low_dur_o | output | DUR_W | Low duration of the last pair |
| period_o | output | DUR_W+1 | High plus low of the last pair |

## Verification
Two decisions are made in the same clock: accepting a low result as the closing half of a pair, and rejecting that same low for a sequence gap. The bench provokes both by presenting a low whose sequence number skips one after a pending high. It judges the result by seeing no strobe in the following cycle and by reading the outputs, which must still hold the previous pair's values. A second overlap is a held high being consumed on the very first edge after reset release. The bench checks this through the pair that the next low produces.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  typedef enum logic {
    ST_WAIT_HI = 1'b0,
    ST_WAIT_LO = 1'b1
  } pair_state_e;
endpackage

// File: rtl/pair_seq_track.sv
module pair_seq_track #(
  parameter int unsigned SEQ_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             res_valid_i,
  input  logic [SEQ_W-1:0] res_seq_i,
  output logic             new_o,
  output logic             gap_o
);
  logic             seen_q;
  logic [SEQ_W-1:0] last_q;
  logic [SEQ_W-1:0] next_exp;

  assign next_exp = SEQ_W'(last_q + 1'b1);
  assign new_o    = res_valid_i && (!seen_q || (res_seq_i != last_q));
  assign gap_o    = seen_q && (res_seq_i != next_exp);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (new_o) begin
      seen_q <= 1'b1;
      last_q <= res_seq_i;
    end
  end

  // R3: a consumed result is remembered so it is not taken twice
  a_r3_consume_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_o |=> (seen_q && (last_q == $past(res_seq_i))));
endmodule

// File: rtl/pair_fsm.sv
module pair_fsm
  import pwm_pair_pkg::*;
#(
  parameter int unsigned DUR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             new_i,
  input  logic             gap_i,
  input  logic             level_i,
  input  logic [DUR_W-1:0] dur_i,
  output logic             fire_o,
  output logic [DUR_W-1:0] hi_o
);
  pair_state_e      state_q, state_d;
  logic [DUR_W-1:0] hi_q, hi_d;

  always_comb begin
    state_d = state_q;
    hi_d    = hi_q;
    fire_o  = 1'b0;
    if (new_i) begin
      unique case (state_q)
        ST_WAIT_HI: begin
          if (level_i) begin
            hi_d    = dur_i;
            state_d = ST_WAIT_LO;
          end
        end
        ST_WAIT_LO: begin
          if (level_i) begin
            hi_d = dur_i;              // newer high replaces pending one
          end else if (!gap_i) begin
            fire_o  = 1'b1;
            state_d = ST_WAIT_HI;
          end else begin
            state_d = ST_WAIT_HI;      // skipped period: drop pending high
          end
        end
        default: state_d = ST_WAIT_HI;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT_HI;
      hi_q    <= '0;
    end else begin
      state_q <= state_d;
      hi_q    <= hi_d;
    end
  end

  assign hi_o = hi_q;

  // R2: a pair can only close from the high-pending state
  a_r2_fire_from_wait_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> (state_q == ST_WAIT_LO));
  // R4: a gapped low never closes a pair
  a_r4_gap_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_i && gap_i && !level_i) |-> !fire_o);
endmodule

// File: rtl/pair_out_reg.sv
module pair_out_reg #(
  parameter int unsigned DUR_W = 16,
  localparam int unsigned PER_W = DUR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [DUR_W-1:0] hi_i,
  input  logic [DUR_W-1:0] lo_i,
  output logic             valid_o,
  output logic [DUR_W-1:0] hi_o,
  output logic [DUR_W-1:0] lo_o,
  output logic [PER_W-1:0] per_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      hi_o    <= '0;
      lo_o    <= '0;
      per_o   <= '0;
    end else begin
      valid_o <= fire_i;
      if (fire_i) begin
        hi_o  <= hi_i;
        lo_o  <= lo_i;
        per_o <= {1'b0, hi_i} + {1'b0, lo_i};
      end
    end
  end

  // R7: outputs only move with a new pair
  a_r7_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> ($stable(hi_o) && $stable(lo_o) && $stable(per_o)));
endmodule

// File: rtl/pwm_pair_capture.sv
module pwm_pair_capture #(
  parameter int unsigned DUR_W = 16,
  parameter int unsigned SEQ_W = 4,
  localparam int unsigned PER_W = DUR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             res_valid_i,
  input  logic             res_level_i,
  input  logic [DUR_W-1:0] res_dur_i,
  input  logic [SEQ_W-1:0] res_seq_i,
  output logic             pair_valid_o,
  output logic [DUR_W-1:0] high_dur_o,
  output logic [DUR_W-1:0] low_dur_o,
  output logic [PER_W-1:0] period_o
);
  logic             new_w, gap_w, fire_w;
  logic [DUR_W-1:0] hi_w;

  pair_seq_track #(.SEQ_W(SEQ_W)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .res_valid_i(res_valid_i),
    .res_seq_i  (res_seq_i),
    .new_o      (new_w),
    .gap_o      (gap_w)
  );

  pair_fsm #(.DUR_W(DUR_W)) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .new_i  (new_w),
    .gap_i  (gap_w),
    .level_i(res_level_i),
    .dur_i  (res_dur_i),
    .fire_o (fire_w),
    .hi_o   (hi_w)
  );

  pair_out_reg #(.DUR_W(DUR_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire_w),
    .hi_i   (hi_w),
    .lo_i   (res_dur_i),
    .valid_o(pair_valid_o),
    .hi_o   (high_dur_o),
    .lo_o   (low_dur_o),
    .per_o  (period_o)
  );

  // R6: strobe lasts a single clock
  a_r6_one_cycle_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_valid_o |=> !pair_valid_o);
  // R2: the result closing a pair was a valid low
  a_r2_closed_by_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_valid_o |-> ($past(res_valid_i) && !$past(res_level_i)));
  // R8: period is the sum of the pair
  a_r8_period_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_valid_o |-> (period_o == ({1'b0, high_dur_o} + {1'b0, low_dur_o})));
endmodule

// File: tb/pwm_pair_capture_bench.sv
module pwm_pair_capture_bench;
  localparam int DUR_W = 16;
  localparam int SEQ_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             res_valid = 1'b0;
  logic             res_level = 1'b0;
  logic [DUR_W-1:0] res_dur = '0;
  logic [SEQ_W-1:0] res_seq = '0;
  logic             pair_valid;
  logic [DUR_W-1:0] high_dur, low_dur;
  logic [DUR_W:0]   period;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwm_pair_capture #(.DUR_W(DUR_W), .SEQ_W(SEQ_W)) u_pwm_pair_capture (
    .clk_i(clk), .rst_ni(rst_n), .res_valid_i(res_valid), .res_level_i(res_level),
    .res_dur_i(res_dur), .res_seq_i(res_seq), .pair_valid_o(pair_valid),
    .high_dur_o(high_dur), .low_dur_o(low_dur), .period_o(period)
  );

  task automatic check(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive a result at a negedge; after the next edge the strobe is visible
  task automatic present(bit lvl, int dur, int seq);
    res_valid = 1'b1;
    res_level = lvl;
    res_dur   = DUR_W'(dur);
    res_seq   = SEQ_W'(seq);
    @(negedge clk);
  endtask

  task automatic expect_pair(string req, int hi, int lo);
    check({req, " strobe"}, pair_valid, 1);
    check({req, " high"}, high_dur, hi);
    check({req, " low"}, low_dur, lo);
    check({req, " period"}, period, hi + lo);
  endtask

  task automatic t_reset();
    check("R1 valid in reset", pair_valid, 0);
    check("R1 period in reset", period, 0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    check("R1 valid after release", pair_valid, 0);
    check("R1 high after release", high_dur, 0);
    check("R1 low after release", low_dur, 0);
  endtask

  task automatic t_basic();
    present(1, 300, 1);
    check("R2 no strobe on high", pair_valid, 0);
    present(0, 700, 2);
    expect_pair("R2_R8 basic", 300, 700);
    @(negedge clk);
    check("R6 strobe one cycle", pair_valid, 0);
  endtask

  task automatic t_low_first();
    present(0, 100, 3);
    check("R10 low ignored", pair_valid, 0);
    check("R10 outputs kept", high_dur, 300);
    present(1, 200, 4);
    check("R2 low-high not paired", pair_valid, 0);
    present(0, 50, 5);
    expect_pair("R2 after low first", 200, 50);
  endtask

  task automatic t_gap();
    present(1, 400, 6);
    present(0, 600, 8);
    check("R4 gapped low no strobe", pair_valid, 0);
    check("R7 high held", high_dur, 200);
    check("R7 low held", low_dur, 50);
    present(0, 70, 9);
    check("R4 high was discarded", pair_valid, 0);
    present(1, 10, 10);
    present(0, 20, 11);
    expect_pair("R4 recover", 10, 20);
  endtask

  task automatic t_replace();
    present(1, 111, 12);
    present(1, 222, 14);
    check("R9 no strobe on high", pair_valid, 0);
    present(0, 333, 15);
    expect_pair("R9 replaced high", 222, 333);
  endtask

  task automatic t_wrap_hold();
    present(1, 500, 0);
    present(0, 600, 1);
    expect_pair("R4 wrap seq", 500, 600);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R3 held low consumed once", pair_valid, 0);
    end
  endtask

  task automatic t_buffered_high();
    rst_n = 1'b0;
    res_valid = 1'b1; res_level = 1'b1; res_dur = 16'd77; res_seq = 4'd5;
    @(negedge clk);
    check("R1 outputs cleared", high_dur, 0);
    rst_n = 1'b1;
    @(negedge clk);
    present(0, 88, 6);
    expect_pair("R5 buffered high", 77, 88);
  endtask

  task automatic t_max();
    present(1, 16'hFFFF, 7);
    present(0, 16'hFFFF, 8);
    expect_pair("R8 max durations", 16'hFFFF, 16'hFFFF);
    check("R8 period top bit", period[DUR_W], 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_low_first();
    t_gap();
    t_replace();
    t_wrap_hold();
    t_buffered_high();
    t_max();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule